// File: doc/BRIEF.md
# Clock Output Control Logic

This block is the digital control core of a two-output spread-spectrum clock generator. For each differential clock output and for the single-ended reference output it decides, every cycle, whether the output runs or sits in its stopped state (both legs low). That decision combines several sources: the active-low per-output enable pins, the power-good/power-down pin, the PLL lock indication, and a small byte-wide register file.

The block also produces the codes that steer the analog side: the spread-spectrum amount for the PLL, the per-output slew and amplitude codes, and the reference slew code. The spread amount comes from one of two places. By default it is a three-level select pin captured when power-good rises. When the software-control bit is set, it is a software field instead. The captured pin value is also returned through a read-only register field.

The serial management engine, the PLL and the output drivers sit outside the block. They connect through a plain register read/write port, a lock input and the per-output run signals.

Top module: `clkctl_top`

## Requirements
- R1: Synchronous active-low reset sets the registers as follows: byte 0 = 0x06, byte 1 = 0x04 (readback), byte 2 = 0x06, byte 3 = 0x50. It also clears the captured spread code to 00 and drives all run outputs low.
- R2: Differential output i (`dif_run[i]`) is 1 one cycle after a clock edge at which all of these hold: power-good is high, lock is qualified, its enable bit (byte 0 bit i+1) is 1, and its pin `oe_n[i]` is 0. Otherwise it is 0 one cycle later.
- R3: An enable bit of 0 in byte 0 forces that differential output stopped, whatever its pin does. The value written takes effect on the run output one cycle after the write edge.
- R4: Lock qualification sets at the first edge where power-good and `pll_locked` are both high. It then stays set when `pll_locked` drops. As a result, a differential output first runs two edges after lock is seen.
- R5: The spread pin code (00 low, 01 mid, 10 or 11 high) is captured at the edge where power-good is first seen high. It reads back in byte 1 bits 7:6 as 00, 01 or 11 respectively, and it holds until the next power-good rise.
- R6: `ssc_code` equals byte 1 bits 4:3 when byte 1 bit 5 is 1. Otherwise it equals the captured pin value. The codes are 00 off, 01 -0.25 %, 10 reserved, 11 -0.5 %.
- R7: `amp_code` is byte 1 bits 2:1 (00 0.6 V, 01 0.68 V, 10 0.75 V, 11 0.85 V). `dif_slew_fast[i]` is byte 2 bit i+1 (1 = fast). `ref_slew` is byte 3 bits 7:6 (00 slowest to 11 fastest).
- R8: `ref_run` is 1 one cycle after an edge where byte 3 bit 4 (reference enable) is 1 and either power-good is high or byte 3 bit 5 (run-in-power-down) is 1.
- R9: While power-good is low, every differential output is stopped one cycle later and lock qualification is cleared. After power-good returns, outputs stay stopped until lock is seen again.
- R10: Writes to reserved bits, to byte 1 bits 7:6 and to byte 4 or above change nothing. Reserved bits read 0, and byte 4 and above read 0.
- R11: A write takes effect at the edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgood | input | 1 | Power-good (1) / power-down (0) |
| ss_sel | input | 2 | Three-level spread select: 00 low, 01 mid, 10 high |
| pll_locked | input | 1 | PLL lock indication |
| oe_n | input | NUM_DIF | Active-low enable pin per differential output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dif_run | output | NUM_DIF | 1 = differential output runs, 0 = stopped low/low |
| ref_run | output | 1 | 1 = reference output runs |
| ssc_code | output | 2 | Spread amount code to the PLL |
| amp_code | output | 2 | Differential output amplitude code |
| dif_slew_fast | output | NUM_DIF | Per-output slew select, 1 = fast |
| ref_slew | output | 2 | Reference slew code |

## Verification
Register fields, `reg_rdata`, `ssc_code`, `amp_code` and the slew codes are due right after the write edge. `dif_run` and `ref_run` are due one edge after their inputs are presented. A lock indication reaches `dif_run` after two edges, and a spread-pin capture shows one edge after power-good rises. The bench drives inputs and samples outputs on the falling edge. A cycle model in the bench advances on each rising edge, so every comparison lands exactly one edge after the stimulus it depends on. Directed steps step one edge at a time to confirm the two-edge lock path and the one-edge write-to-stop path.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helper functions for the clock output control logic.
// Assumes byte-wide registers; register layout depends on the number of differential outputs.
package clkctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int REG_COUNT = 4;

    localparam int ADR_OE    = 0;
    localparam int ADR_SS    = 1;
    localparam int ADR_SLEW  = 2;
    localparam int ADR_REF   = 3;

    localparam int SS_SWEN_BIT = 5;
    localparam int REF_WOL_BIT = 5;
    localparam int REF_OE_BIT  = 4;

    typedef enum logic [1:0] {
        SS_OFF     = 2'b00,
        SS_QUARTER = 2'b01,
        SS_RSVD    = 2'b10,
        SS_HALF    = 2'b11
    } ss_code_t;

    // Bits occupied by one-bit-per-output fields (bit i+1 for output i).
    function automatic logic [BYTE_W-1:0] per_out_mask(input int ndif);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int i = 0; i < ndif; i++) m[i+1] = 1'b1;
        return m;
    endfunction

    // Writable and readable bits of each stored register byte.
    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx, input int ndif);
        case (idx)
            ADR_OE:   return per_out_mask(ndif);
            ADR_SS:   return 8'h3E;
            ADR_SLEW: return per_out_mask(ndif);
            default:  return 8'hF0;
        endcase
    endfunction

    // Reset value of each stored register byte.
    function automatic logic [BYTE_W-1:0] reg_reset(input int idx, input int ndif);
        case (idx)
            ADR_OE:   return per_out_mask(ndif);
            ADR_SS:   return 8'h04;
            ADR_SLEW: return per_out_mask(ndif);
            default:  return 8'h50;
        endcase
    endfunction

    // Maps the three-level pin code onto a spread code.
    function automatic ss_code_t map_sel(input logic [1:0] pin);
        case (pin)
            2'b00:   return SS_OFF;
            2'b01:   return SS_QUARTER;
            default: return SS_HALF;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_regs.sv
`timescale 1ns/1ps
// Module: byte-wide control register file.
// Stores only writable bits; reserved bits read 0; byte 1 bits 7:6 return the
// captured spread pin code; addresses at or above REG_COUNT are reserved.
// Assumes a single-cycle write strobe and combinational read.
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int NUM_DIF = 2,
    parameter int ADDR_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [1:0]          pin_code,
    output logic [BYTE_W-1:0]   rdata,
    output logic [NUM_DIF-1:0]  oe_bits,
    output logic [NUM_DIF-1:0]  slew_bits,
    output logic                ss_sw_en,
    output logic [1:0]          ss_sw_code,
    output logic [1:0]          amp,
    output logic [1:0]          ref_slew_code,
    output logic                ref_wol,
    output logic                ref_oe
);

    logic [REG_COUNT-1:0][BYTE_W-1:0] byte_q;

    for (genvar k = 0; k < REG_COUNT; k++) begin : g_byte
        localparam logic [BYTE_W-1:0] WMASK = reg_wmask(k, NUM_DIF);
        localparam logic [BYTE_W-1:0] RVAL  = reg_reset(k, NUM_DIF);
        logic [BYTE_W-1:0] q;

        // Holds one register byte; only writable bits ever change.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RVAL;
            else if (wr && addr == ADDR_W'(k))
                q <= (q & ~WMASK) | (wdata & WMASK);
        end

        assign byte_q[k] = q;
    end

    // Read multiplexer with read-only overlay and reserved masking.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < REG_COUNT; k++) begin
            if (addr == ADDR_W'(k))
                rdata = byte_q[k] & reg_wmask(k, NUM_DIF);
        end
        if (addr == ADDR_W'(ADR_SS))
            rdata[7:6] = pin_code;
    end

    assign oe_bits       = byte_q[ADR_OE][NUM_DIF:1];
    assign slew_bits     = byte_q[ADR_SLEW][NUM_DIF:1];
    assign ss_sw_en      = byte_q[ADR_SS][SS_SWEN_BIT];
    assign ss_sw_code    = byte_q[ADR_SS][4:3];
    assign amp           = byte_q[ADR_SS][2:1];
    assign ref_slew_code = byte_q[ADR_REF][7:6];
    assign ref_wol       = byte_q[ADR_REF][REF_WOL_BIT];
    assign ref_oe        = byte_q[ADR_REF][REF_OE_BIT];

    // R10: a write to a reserved address leaves every stored byte unchanged.
    assert_rsvd_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr >= ADDR_W'(REG_COUNT)) |=> $stable(byte_q));

    // R11: software spread enable follows the written bit after the write edge.
    assert_wr_visible_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(ADR_SS)) |=> (ss_sw_en == $past(wdata[SS_SWEN_BIT])));

endmodule

// File: rtl/clkctl_pwrseq.sv
`timescale 1ns/1ps
// Module: power-good sequencing.
// Detects the power-good rise, captures the spread select pin at that edge, and
// tracks lock qualification, which is sticky until power-good falls.
// Assumes pgood, ss_sel and pll_locked are already synchronous to clk.
module clkctl_pwrseq
    import clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pgood,
    input  logic [1:0] ss_sel,
    input  logic       pll_locked,
    output logic [1:0] pin_code,
    output logic       lock_ok
);

    logic pg_q;

    // Remembers last cycle's power-good for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pgood;
    end

    // Captures the spread select pin on the power-good rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_code <= SS_OFF;
        else if (pgood && !pg_q)
            pin_code <= map_sel(ss_sel);
    end

    // Sets lock qualification on lock while powered; clears in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_ok <= 1'b0;
        else if (!pgood)
            lock_ok <= 1'b0;
        else if (pll_locked)
            lock_ok <= 1'b1;
    end

    // R5: the captured code holds while power-good stays high.
    assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood && pg_q) |=> $stable(pin_code));

    // R9: power-down clears lock qualification at the next edge.
    assert_lock_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood |=> !lock_ok);

    // R4: once qualified and still powered, qualification does not drop.
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok && pgood) |=> lock_ok);

endmodule

// File: rtl/clkctl_outgate.sv
`timescale 1ns/1ps
// Module: output run gating.
// Registers one run flag per differential output and one for the reference.
// A stopped differential output means both legs are held low by the driver.
// Assumes lock_ok already includes the power-good condition history.
module clkctl_outgate #(
    parameter int NUM_DIF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pgood,
    input  logic               lock_ok,
    input  logic [NUM_DIF-1:0] oe_bits,
    input  logic [NUM_DIF-1:0] oe_n,
    input  logic               ref_oe,
    input  logic               ref_wol,
    output logic [NUM_DIF-1:0] dif_run,
    output logic               ref_run
);

    for (genvar i = 0; i < NUM_DIF; i++) begin : g_dif
        logic run_q;

        // Runs output i only when powered, locked, register-enabled and pin-enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= pgood & lock_ok & oe_bits[i] & ~oe_n[i];
        end

        assign dif_run[i] = run_q;

        // R3: a cleared enable bit stops the output at the next edge.
        assert_reg_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_bits[i] |=> !dif_run[i]);

        // R4: a running output was lock-qualified on the previous edge.
        assert_run_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dif_run[i] |-> $past(lock_ok));

        // R9: power-down stops the output at the next edge.
        assert_pd_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !pgood |=> !dif_run[i]);
    end

    // Runs the reference when enabled, and in power-down only with wake support.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_run <= 1'b0;
        else        ref_run <= ref_oe & (pgood | ref_wol);
    end

    // R8: without wake support the reference stops in power-down.
    assert_ref_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgood && !ref_wol) |=> !ref_run);

endmodule

// File: rtl/clkctl_top.sv
`timescale 1ns/1ps
// Module: top of the clock output control logic.
// Connects register file, power sequencing and output gating, and selects the
// spread code between the captured pin value and the software field.
// Assumes all inputs are synchronous to clk.
module clkctl_top
    import clkctl_pkg::*;
#(
    parameter int NUM_DIF = 2,
    parameter int ADDR_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pgood,
    input  logic [1:0]         ss_sel,
    input  logic               pll_locked,
    input  logic [NUM_DIF-1:0] oe_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic [NUM_DIF-1:0] dif_run,
    output logic               ref_run,
    output logic [1:0]         ssc_code,
    output logic [1:0]         amp_code,
    output logic [NUM_DIF-1:0] dif_slew_fast,
    output logic [1:0]         ref_slew
);

    logic [1:0]         pin_code;
    logic               lock_ok;
    logic [NUM_DIF-1:0] oe_bits;
    logic               ss_sw_en;
    logic [1:0]         ss_sw_code;
    logic               ref_wol;
    logic               ref_oe;

    clkctl_regs #(.NUM_DIF(NUM_DIF), .ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (reg_wr),
        .addr          (reg_addr),
        .wdata         (reg_wdata),
        .pin_code      (pin_code),
        .rdata         (reg_rdata),
        .oe_bits       (oe_bits),
        .slew_bits     (dif_slew_fast),
        .ss_sw_en      (ss_sw_en),
        .ss_sw_code    (ss_sw_code),
        .amp           (amp_code),
        .ref_slew_code (ref_slew),
        .ref_wol       (ref_wol),
        .ref_oe        (ref_oe)
    );

    clkctl_pwrseq u_pwrseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pgood      (pgood),
        .ss_sel     (ss_sel),
        .pll_locked (pll_locked),
        .pin_code   (pin_code),
        .lock_ok    (lock_ok)
    );

    clkctl_outgate #(.NUM_DIF(NUM_DIF)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgood   (pgood),
        .lock_ok (lock_ok),
        .oe_bits (oe_bits),
        .oe_n    (oe_n),
        .ref_oe  (ref_oe),
        .ref_wol (ref_wol),
        .dif_run (dif_run),
        .ref_run (ref_run)
    );

    // Picks the software spread field only when software control is enabled.
    always_comb begin
        ssc_code = ss_sw_en ? ss_sw_code : pin_code;
    end

    // R6: with software control off, the PLL sees the captured pin value.
    assert_ss_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_sw_en |-> (ssc_code == pin_code));

endmodule

// File: tb/sim_clkctl_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random stimulus against a cycle model.
module sim_clkctl_top;

    localparam int ND = 2;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pgood = 1'b0;
    logic [1:0] ss_sel = 2'b00;
    logic pll_locked = 1'b0;
    logic [ND-1:0] oe_n = '1;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [ND-1:0] dif_run;
    logic ref_run;
    logic [1:0] ssc_code, amp_code, ref_slew;
    logic [ND-1:0] dif_slew_fast;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    clkctl_top #(.NUM_DIF(ND), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .pgood(pgood), .ss_sel(ss_sel),
        .pll_locked(pll_locked), .oe_n(oe_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dif_run(dif_run), .ref_run(ref_run), .ssc_code(ssc_code),
        .amp_code(amp_code), .dif_slew_fast(dif_slew_fast), .ref_slew(ref_slew)
    );

    // Cycle model built from the requirements.
    logic [7:0] m_b0, m_b1, m_b2, m_b3;
    logic [1:0] m_sel;
    logic m_pgq, m_lock, m_ref;
    logic [ND-1:0] m_dif;

    function automatic logic [1:0] sel_map(input logic [1:0] p);
        return (p == 2'b00) ? 2'b00 : (p == 2'b01) ? 2'b01 : 2'b11;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [AW-1:0] a);
        case (a)
            3'd0: return m_b0;
            3'd1: return {m_sel, m_b1[5:0]};
            3'd2: return m_b2;
            3'd3: return m_b3;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] exp_ssc();
        return m_b1[5] ? m_b1[4:3] : m_sel;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_b0 <= 8'h06; m_b1 <= 8'h04; m_b2 <= 8'h06; m_b3 <= 8'h50;
            m_sel <= 2'b00; m_pgq <= 1'b0; m_lock <= 1'b0;
            m_dif <= '0; m_ref <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_b0 <= reg_wdata & 8'h06;
                    3'd1: m_b1 <= reg_wdata & 8'h3E;
                    3'd2: m_b2 <= reg_wdata & 8'h06;
                    3'd3: m_b3 <= reg_wdata & 8'hF0;
                    default: ;
                endcase
            end
            m_pgq <= pgood;
            if (pgood && !m_pgq) m_sel <= sel_map(ss_sel);
            m_lock <= pgood ? (m_lock | pll_locked) : 1'b0;
            for (int i = 0; i < ND; i++)
                m_dif[i] <= pgood & m_lock & m_b0[i+1] & ~oe_n[i];
            m_ref <= m_b3[4] & (pgood | m_b3[5]);
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Compares every output with the model at the falling edge.
    task automatic cycle_checks();
        chk("R2 R3 R4 dif_run", 8'(dif_run), 8'(m_dif));
        chk("R8 ref_run", 8'(ref_run), 8'(m_ref));
        chk("R6 ssc_code", 8'(ssc_code), 8'(exp_ssc()));
        chk("R7 amp_code", 8'(amp_code), 8'(m_b1[2:1]));
        chk("R7 dif_slew_fast", 8'(dif_slew_fast), 8'(m_b2[2:1]));
        chk("R7 ref_slew", 8'(ref_slew), 8'(m_b3[7:6]));
        chk("R10 R11 reg_rdata", reg_rdata, exp_rdata(reg_addr));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) cycle_checks();
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string req);
        reg_addr = AW'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(0, 8'h06, "R1 byte0");
        rd(1, 8'h04, "R1 byte1");
        rd(2, 8'h06, "R1 byte2");
        rd(3, 8'h50, "R1 byte3");
        chk("R1 dif_run", 8'(dif_run), 8'h00);
        chk("R1 ref_run", 8'(ref_run), 8'h00);
        chk("R1 ssc_code", 8'(ssc_code), 8'h00);
        rst_n = 1'b1; ss_sel = 2'b10; oe_n = 2'b00;
        step();
        chk("R5 no capture while powered down", 8'(ssc_code), 8'h00);
        pgood = 1'b1;
        step();
        rd(1, 8'hC4, "R5 high pin readback");
        chk("R6 pin spread", 8'(ssc_code), 8'h03);
        chk("R4 no lock yet", 8'(dif_run), 8'h00);
        ss_sel = 2'b01;
        step(); step();
        rd(1, 8'hC4, "R5 hold");
        pll_locked = 1'b1;
        step();
        chk("R4 first edge after lock", 8'(dif_run), 8'h00);
        step();
        chk("R2 both running", 8'(dif_run), 8'h03);
        pll_locked = 1'b0;
        step();
        chk("R4 lock sticky", 8'(dif_run), 8'h03);
        oe_n = 2'b01;
        step();
        chk("R2 pin stops output0", 8'(dif_run), 8'h02);
        oe_n = 2'b00;
        wr(0, 8'h02);
        chk("R3 write edge uses old bits", 8'(dif_run), 8'h03);
        step();
        chk("R3 override output1", 8'(dif_run), 8'h01);
        wr(1, 8'h28);
        rd(1, 8'hE8, "R10 read-only bits kept");
        chk("R6 software spread", 8'(ssc_code), 8'h01);
        chk("R7 amplitude", 8'(amp_code), 8'h00);
        wr(4, 8'hFF);
        rd(4, 8'h00, "R10 byte4 reads zero");
        rd(0, 8'h02, "R10 byte0 untouched");
        pgood = 1'b0;
        step();
        chk("R9 power-down stops", 8'(dif_run), 8'h00);
        chk("R8 ref off in power-down", 8'(ref_run), 8'h00);
        wr(3, 8'h30);
        step();
        chk("R8 ref with wake bit", 8'(ref_run), 8'h01);
        chk("R7 ref slew", 8'(ref_slew), 8'h00);
        ss_sel = 2'b00; pgood = 1'b1;
        step(); step(); step();
        chk("R9 stays stopped without lock", 8'(dif_run), 8'h00);
        rd(1, 8'h28, "R5 recapture on power-good rise");

        // Seeded random phase checked against the model every cycle.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 99) < 3)  pgood = ~pgood;
            if ($urandom_range(0, 99) < 10) pll_locked = ~pll_locked;
            if ($urandom_range(0, 99) < 15) oe_n = ND'($urandom);
            ss_sel = 2'($urandom);
            reg_wr = ($urandom_range(0, 99) < 25);
            reg_addr = AW'($urandom);
            reg_wdata = 8'($urandom);
            if ($urandom_range(0, 199) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            step();
        end
        reg_wr = 1'b0; rst_n = 1'b1;
        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule